// File: doc/BRIEF.md
# Serial ADC Conversion Host Controller

This block is the host-side master for a serial analog-to-digital converter that is driven over three wires: a conversion strobe, a serial clock and a serial data line. A conversion begins when the strobe falls. The controller then issues sixteen serial clock periods and samples the data line on every falling clock edge. Each frame carries three leading zeros, a 12-bit result with the most significant bit first, and one trailing zero. The result is presented as a single-cycle valid pulse with its data word. While `cont_en` is held high, frames follow one another without a command between them. The strobe rises early, between the 14th and 15th rising clock edges, so that the next conversion is armed.

The same wires also carry power-management commands. The rising edge of the strobe is placed at a chosen point in the frame, counted in rising serial clock edges, and that position tells the converter which operation is meant. A short frame, with the strobe raised after the 4th rising edge, steps the converter from normal mode down to partial power-down. The same short frame, issued again while the converter is in partial power-down, moves it on to full power-down. A long frame, with the strobe held low for sixteen rising edges, wakes the converter. The controller keeps its own record of the converter's power mode and refuses any command that does not fit that mode. The serial clock runs at the system clock divided by `2*DIV_N`. After every frame the strobe stays high for at least `2*DIV_N` system cycles.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is applied and right after it, `cnv_o` is 1, `sclk_o` is 0, `res_valid` and `cmd_err` are 0, and `pmode` is 2'b00 (normal). `cmd_ready` is 0 while the internal synchronised reset is active.
- R2: An accepted conversion (`cmd_op` 2'b00) drives `cnv_o` low in the cycle after the handshake. `sclk_o` stays low for `DIV_N` cycles and then toggles every `DIV_N` cycles, giving exactly 16 rising edges. Outside a frame, `sclk_o` stays low.
- R3: `sdata_i` is sampled on each falling edge of `sclk_o`. The bits sampled at falling edges 4 to 15 form `res_data`, MSB first. `res_valid` is high for exactly one cycle: the cycle after the system clock edge that produces the 15th falling edge.
- R4: In a single conversion, `cnv_o` rises together with the 16th falling edge. It then stays high for `2*DIV_N` cycles before `cmd_ready` returns.
- R5: If `cont_en` is high when the 14th falling edge occurs, `cnv_o` rises at that edge instead. The frame still completes its 16 edges, and a new conversion frame starts by itself `2*DIV_N` cycles after the 16th falling edge.
- R6: `cmd_op` 2'b01 (partial power-down), when `pmode` is normal, runs a frame of 4 rising edges. `cnv_o` rises with the 4th falling edge, and `pmode` becomes 2'b01.
- R7: `cmd_op` 2'b10 (full power-down), when `pmode` is 2'b01, runs the same 4-edge frame and sets `pmode` to 2'b10.
- R8: A command that does not fit the tracked mode is consumed without any frame. Such a command is: a conversion or a partial power-down outside normal mode, a full power-down outside partial mode, or a wake in normal mode. `cmd_err` pulses for one cycle, `cnv_o` and `sclk_o` do not move, and `pmode` is unchanged.
- R9: `cmd_op` 2'b11 (wake), in either power-down mode, holds `cnv_o` low for 16 rising edges. It produces no `res_valid` and returns `pmode` to 2'b00.
- R10: `cmd_ready` is high only when the controller is idle. With `cmd_valid` held high, back-to-back conversions are accepted `32*DIV_N + 2*DIV_N + 1` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle; a command is taken when both are high |
| cmd_op | input | 2 | 00 convert, 01 partial power-down, 10 full power-down, 11 wake |
| cont_en | input | 1 | Chain conversion frames back to back |
| cmd_err | output | 1 | One-cycle pulse for a command refused in the current mode |
| pmode | output | 2 | Tracked converter mode: 00 normal, 01 partial, 10 full |
| cnv_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Conversion result |

## Verification
Every result has a fixed due cycle, counted from the handshake edge. The strobe falls one cycle after it. Rising serial clock edge k appears `(2k-1)*DIV_N` cycles after it and falling edge k appears `2k*DIV_N` cycles after it. The result pulse arrives `30*DIV_N` cycles after the handshake, the tracked mode changes on the edge that ends the frame, and the error pulse comes one cycle after a refused handshake. The bench holds a behavioural model that counts cycles from each handshake with plain integers. At every falling system clock edge it compares each output against the value due in that cycle, so an edge that comes one cycle early or late is reported. A converter model in the bench counts the rising serial clock edges it sees. It records where the strobe rose, so that the short, long and early-strobe frames are also checked by their edge counts.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

  typedef enum logic [1:0] {
    OP_CONV    = 2'b00,
    OP_PD_PART = 2'b01,
    OP_PD_FULL = 2'b10,
    OP_WAKE    = 2'b11
  } host_op_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_PART   = 2'b01,
    PM_FULL   = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FRAME = 2'b01,
    ST_GAP   = 2'b10
  } seq_st_e;

endpackage

// File: rtl/adc_rst_sync.sv
`timescale 1ns/1ps
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
  parameter int unsigned DIV_N  = 2,
  parameter int unsigned HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  output logic              sclk,
  output logic              fall_tick,
  output logic [HALF_W-1:0] half_nxt
);

  localparam int unsigned DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_N - 1);

  logic [DIV_W-1:0]  div_q, div_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              sclk_q, sclk_d;
  logic              tick;

  assign tick      = run && (div_q == DIV_LAST);
  assign fall_tick = tick && sclk_q;
  assign half_nxt  = half_q + HALF_W'(1);
  assign sclk      = sclk_q;

  always_comb begin
    div_d  = div_q;
    half_d = half_q;
    sclk_d = sclk_q;
    if (start) begin
      div_d  = '0;
      half_d = '0;
      sclk_d = 1'b0;
    end else if (run) begin
      if (tick) begin
        div_d  = '0;
        half_d = half_nxt;
        sclk_d = !sclk_q;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      half_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      half_q <= half_d;
      sclk_q <= sclk_d;
    end
  end

  // R2
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(sclk_q));

endmodule

// File: rtl/adc_rx_shift.sv
`timescale 1ns/1ps
module adc_rx_shift #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             capture,
  input  logic             sdata,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);

  logic [RES_W-1:0] sh_q, sh_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;

  always_comb begin
    sh_d  = shift_en ? {sh_q[RES_W-2:0], sdata} : sh_q;
    vld_d = capture && shift_en;
    res_d = vld_d ? sh_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/adc_serial_host.sv
`timescale 1ns/1ps
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int unsigned DIV_N       = 2,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned LEAD_ZEROS  = 3,
  parameter int unsigned FRAME_EDGES = 16,
  parameter int unsigned PD_EDGE     = 4,
  parameter int unsigned CONT_EDGE   = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cont_en,
  output logic             cmd_err,
  output logic [1:0]       pmode,
  output logic             cnv_o,
  output logic             sclk_o,
  input  logic             sdata_i,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);

  localparam int unsigned HALF_W  = $clog2(2*FRAME_EDGES + 1);
  localparam int unsigned GAP_CYC = 2*DIV_N;
  localparam int unsigned GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [HALF_W-1:0] H_END_LONG  = HALF_W'(2*FRAME_EDGES);
  localparam logic [HALF_W-1:0] H_END_SHORT = HALF_W'(2*PD_EDGE);
  localparam logic [HALF_W-1:0] H_CONT      = HALF_W'(2*CONT_EDGE);
  localparam logic [HALF_W-1:0] H_LAST_BIT  = HALF_W'(2*(LEAD_ZEROS + RES_W));
  localparam logic [GAP_W-1:0]  GAP_LAST    = GAP_W'(GAP_CYC - 1);

  logic rst_ns;

  seq_st_e     st_q, st_d;
  host_op_e    op_q, op_d, op_in;
  pwr_mode_e   mode_q, mode_d;
  logic        cont_q, cont_d;
  logic        cnv_q, cnv_d;
  logic        err_q, err_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  logic              accept, legal, start, run, capture, short_op;
  logic              fall_tick;
  logic [HALF_W-1:0] half_nxt;
  logic [HALF_W-1:0] half_end;

  adc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_ns)
  );

  adc_sclk_gen #(.DIV_N(DIV_N), .HALF_W(HALF_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (start),
    .run       (run),
    .sclk      (sclk_o),
    .fall_tick (fall_tick),
    .half_nxt  (half_nxt)
  );

  adc_rx_shift #(.RES_W(RES_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_ns),
    .shift_en  (fall_tick),
    .capture   (capture),
    .sdata     (sdata_i),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  assign op_in     = host_op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE) && rst_ns;
  assign accept    = cmd_valid && cmd_ready;
  assign run       = (st_q == ST_FRAME);
  assign short_op  = (op_q == OP_PD_PART) || (op_q == OP_PD_FULL);
  assign half_end  = short_op ? H_END_SHORT : H_END_LONG;
  assign capture   = run && (op_q == OP_CONV) && (half_nxt == H_LAST_BIT);

  always_comb begin
    unique case (op_in)
      OP_CONV, OP_PD_PART: legal = (mode_q == PM_NORMAL);
      OP_PD_FULL:          legal = (mode_q == PM_PART);
      default:             legal = (mode_q != PM_NORMAL);
    endcase
  end

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    mode_d = mode_q;
    cont_d = cont_q;
    cnv_d  = cnv_q;
    gap_d  = gap_q;
    err_d  = 1'b0;
    start  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (legal) begin
            st_d   = ST_FRAME;
            op_d   = op_in;
            cont_d = 1'b0;
            cnv_d  = 1'b0;
            start  = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_FRAME: begin
        if (fall_tick) begin
          if ((op_q == OP_CONV) && (half_nxt == H_CONT)) begin
            cont_d = cont_en;
            if (cont_en) cnv_d = 1'b1;
          end
          if (half_nxt == half_end) begin
            st_d  = ST_GAP;
            gap_d = '0;
            cnv_d = 1'b1;
            unique case (op_q)
              OP_PD_PART: mode_d = PM_PART;
              OP_PD_FULL: mode_d = PM_FULL;
              OP_WAKE:    mode_d = PM_NORMAL;
              default:    mode_d = mode_q;
            endcase
          end
        end
      end
      default: begin
        if (gap_q == GAP_LAST) begin
          if (cont_q) begin
            st_d   = ST_FRAME;
            cont_d = 1'b0;
            cnv_d  = 1'b0;
            start  = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_CONV;
      mode_q <= PM_NORMAL;
      cont_q <= 1'b0;
      cnv_q  <= 1'b1;
      err_q  <= 1'b0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      mode_q <= mode_d;
      cont_q <= cont_d;
      cnv_q  <= cnv_d;
      err_q  <= err_d;
      gap_q  <= gap_d;
    end
  end

  assign cnv_o   = cnv_q;
  assign cmd_err = err_q;
  assign pmode   = mode_q;

  // R2
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q != ST_FRAME) |-> !sclk_o);

  // R4
  ready_strobe_hi_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_ready |-> cnv_o);

  // R5
  strobe_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(cnv_o) |-> !sclk_o);

  // R6
  part_from_normal_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_q == PM_PART && $past(mode_q) != PM_PART) |-> $past(mode_q) == PM_NORMAL);

  // R7
  full_from_part_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_q == PM_FULL && $past(mode_q) != PM_FULL) |-> $past(mode_q) == PM_PART);

  // R8
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_err |-> (cmd_ready && cnv_o && $stable(mode_q)));

  // R9
  no_result_off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    res_valid |-> (op_q == OP_CONV));

endmodule

// File: tb/tb_adc_serial_host.sv
`timescale 1ns/1ps
module tb_adc_serial_host;

  localparam int DN = 2;
  localparam int FRAME_CYC = 32*DN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cont_en = 1'b0;
  logic sdata = 1'b0;
  logic cmd_ready, cmd_err, cnv_o, sclk_o, res_valid;
  logic [1:0] pmode;
  logic [11:0] res_data;

  adc_serial_host #(.DIV_N(DN)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cont_en(cont_en), .cmd_err(cmd_err), .pmode(pmode),
    .cnv_o(cnv_o), .sclk_o(sclk_o), .sdata_i(sdata),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #2.5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit chk_on  = 0;

  // reference model state
  int m_st = 0, m_t = 0, m_op = 0, m_mode = 0;
  bit m_cont = 0, m_err = 0, m_val = 0;

  // converter model state
  logic [11:0] cur_word = 12'h000;
  int rcount = 0, last_rises = 0, frame_no = 0, vcount = 0, early_rises = 0;
  logic p_cnv = 1'b1, p_sclk = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int edges_of(int op);
    return (op == 1 || op == 2) ? 4 : 16;
  endfunction

  function automatic bit legal_of(int op, int md);
    case (op)
      0, 1:    return md == 0;
      2:       return md == 1;
      default: return md != 0;
    endcase
  endfunction

  function automatic logic [11:0] word_for(int k);
    case (k % 4)
      1:       return 12'h000;
      2:       return 12'hFFF;
      3:       return 12'h800;
      default: return 12'((k * 419) ^ 12'h5A3);
    endcase
  endfunction

  // behavioural reference, advanced on every rising clock edge
  always @(posedge clk) begin
    m_err = 0;
    m_val = 0;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_mode = 0; m_cont = 0;
    end else if (m_st == 0) begin
      if (cmd_valid && chk_on) begin
        if (legal_of(cmd_op, m_mode)) begin
          m_st = 1; m_t = 0; m_op = cmd_op; m_cont = 0;
        end else m_err = 1;
      end
    end else if (m_st == 1) begin
      m_t++;
      if (m_op == 0 && m_t == 28*DN) m_cont = cont_en;
      if (m_op == 0 && m_t == 30*DN) m_val = 1;
      if (m_t == 2*edges_of(m_op)*DN) begin
        m_st = 2; m_t = 0;
        if (m_op == 1) m_mode = 1;
        else if (m_op == 2) m_mode = 2;
        else if (m_op == 3) m_mode = 0;
      end
    end else begin
      m_t++;
      if (m_t == 2*DN) begin
        if (m_cont) begin m_st = 1; m_t = 0; m_cont = 0; end
        else m_st = 0;
      end
    end
  end

  // comparison and converter model, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      int e_sclk, e_cnv;
      e_sclk = (m_st == 1) ? ((m_t / DN) % 2) : 0;
      e_cnv  = (m_st == 1) ? int'(m_cont) : 1;
      chk(sclk_o === 1'(e_sclk), "R2 sclk_o", sclk_o, e_sclk);
      chk(cnv_o === 1'(e_cnv), "R4 R5 cnv_o", cnv_o, e_cnv);
      chk(cmd_ready === (m_st == 0), "R10 cmd_ready", cmd_ready, int'(m_st == 0));
      chk(cmd_err === m_err, "R8 cmd_err", cmd_err, m_err);
      chk(pmode === 2'(m_mode), "R6 R7 R9 pmode", pmode, m_mode);
      chk(res_valid === m_val, "R3 res_valid", res_valid, m_val);
      if (m_val) chk(res_data === cur_word, "R3 res_data", res_data, cur_word);
    end
    if (res_valid) vcount++;
    if (p_cnv && !cnv_o) begin
      frame_no++;
      cur_word = word_for(frame_no);
      rcount = 0;
    end
    if (!p_sclk && sclk_o) begin
      rcount++;
      sdata = (rcount >= 4 && rcount <= 15) ? cur_word[15 - rcount] : 1'b0;
    end
    if (!p_cnv && cnv_o) begin
      last_rises = rcount;
      if (rcount == 14) early_rises++;
    end
    p_cnv  = cnv_o;
    p_sclk = sclk_o;
  end

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    int v0, f0, last_acc;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk(cnv_o === 1'b1, "R1 strobe in reset", cnv_o, 1);
    chk(sclk_o === 1'b0, "R1 sclk in reset", sclk_o, 0);
    chk(cmd_ready === 1'b0, "R1 ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(cmd_ready === 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(pmode === 2'b00, "R1 mode", pmode, 0);
    chk(res_valid === 1'b0 && cmd_err === 1'b0, "R1 pulses", res_valid, 0);
    chk_on = 1;

    // R2 R3 R4: single conversions
    issue(2'b00); wait_idle();
    chk(last_rises == 16, "R4 strobe at 16th edge", last_rises, 16);
    issue(2'b00); wait_idle();
    chk(vcount == 2, "R3 result count", vcount, 2);

    // R5: continuous conversion
    f0 = frame_no;
    cont_en = 1'b1;
    issue(2'b00);
    while (frame_no < f0 + 3) @(negedge clk);
    cont_en = 1'b0;
    wait_idle();
    chk(early_rises >= 2, "R5 early strobe frames", early_rises, 2);
    chk(last_rises == 16, "R5 chain ends with full frame", last_rises, 16);

    // R8: refused in normal mode
    issue(2'b10); repeat (3) @(negedge clk);
    chk(pmode === 2'b00, "R8 full from normal", pmode, 0);
    issue(2'b11); repeat (3) @(negedge clk);
    chk(pmode === 2'b00, "R8 wake in normal", pmode, 0);

    // R6
    issue(2'b01); wait_idle();
    chk(pmode === 2'b01, "R6 mode partial", pmode, 1);
    chk(last_rises == 4, "R6 short frame", last_rises, 4);

    // R8: refused in partial mode
    v0 = vcount;
    issue(2'b00); repeat (3) @(negedge clk);
    issue(2'b01); repeat (3) @(negedge clk);
    chk(pmode === 2'b01 && vcount == v0, "R8 partial kept", pmode, 1);

    // R7
    issue(2'b10); wait_idle();
    chk(pmode === 2'b10, "R7 mode full", pmode, 2);
    chk(last_rises == 4, "R7 short frame", last_rises, 4);

    // R9
    v0 = vcount;
    issue(2'b11); wait_idle();
    chk(pmode === 2'b00, "R9 mode normal", pmode, 0);
    chk(last_rises == 16, "R9 long low strobe", last_rises, 16);
    chk(vcount == v0, "R9 no result", vcount, v0);

    // R10: back-to-back spacing with valid held
    last_acc = -1;
    @(negedge clk);
    cmd_op = 2'b00;
    cmd_valid = 1'b1;
    for (int i = 0; i < 160; i++) begin
      if (cmd_ready) begin
        if (last_acc >= 0)
          chk(i - last_acc == FRAME_CYC + 2*DN + 1, "R10 spacing",
              i - last_acc, FRAME_CYC + 2*DN + 1);
        last_acc = i;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule